// File: doc/BRIEF.md
# Processor Run-Control Coprocessor

This block stands between a host command channel and a small multi-cycle processor core and decides when the core may execute. The host stages a value in an argument register and then copies it into the core's program counter with a separate command. It can start the core, which then runs until it retires the stop instruction, or start a budgeted run that lasts a fixed number of clock cycles. The host can also halt the core directly.

While the core runs, two saturating counters track the clock cycles spent running and the instructions retired. The host reads either counter through the command channel. When the core halts itself, either by retiring the stop word or by using up its cycle budget, the block raises an interrupt. A cause bit tells the host which of the two events caused the halt. Every command gets exactly one response: OK, DATA or ERROR.

Top module: `rc_run_ctrl`

## Requirements
- R1: After reset, `core_run`, `irq`, `irq_cause`, `rsp_valid`, `core_pc_load` and `core_pc` are all zero, and both counters read zero.
- R2: Code 0 stores `cmd_arg` in the argument register and has no other visible effect. Code 2 copies the argument register to `core_pc` and pulses `core_pc_load` high for one cycle. Both answer OK.
- R3: Each accepted command cycle is followed, in the next cycle only, by one `rsp_valid` cycle. `rsp_kind` is 0 for OK, 1 for DATA and 2 for ERROR. No response appears without a command.
- R4: Code 1 drives `core_run` high from the next cycle, clears both counters and clears `irq` and `irq_cause`.
- R5: A retire strobe while running, with `core_instr` equal to 0x40800000, drops `core_run` in the next cycle. It also raises `irq` with `irq_cause` 0. This cause takes priority when the budget ends in the same cycle.
- R6: Code 3 takes a cycle budget N in `cmd_arg`. It loads `core_pc` from the argument register with a `core_pc_load` pulse, clears the counters and `irq`, and holds `core_run` high for exactly N cycles. At the end it raises `irq` with `irq_cause` 1. N equal to 0 is answered with ERROR and changes nothing.
- R7: The cycle counter advances on every clock edge on which `core_run` is high. The instruction counter advances on every retire strobe seen while running. Retire strobes while halted are ignored. Code 5 returns the cycle count as DATA, and code 6 returns the instruction count as DATA.
- R8: Both counters stop at 2^CNT_W-1 and do not wrap.
- R9: Code 4 halts the core in the next cycle without raising `irq`, and answers OK.
- R10: `irq` and `irq_cause` hold until code 7 (clear interrupt), code 1 or an accepted code 3. `irq` is never high while `core_run` is high.
- R11: While running, codes 0, 1, 2, 3 and 7 are answered with ERROR and have no effect. Codes 4, 5 and 6 are still accepted.
- R12: Codes 8 to 15 are answered with ERROR at all times and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 4 | Command code |
| cmd_arg | input | DATA_W | Command argument or cycle budget |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | 0 OK, 1 DATA, 2 ERROR |
| rsp_data | output | DATA_W | Counter value for DATA responses, otherwise zero |
| core_run | output | 1 | Core enable |
| core_pc_load | output | 1 | One-cycle strobe: load `core_pc` into the core |
| core_pc | output | DATA_W | Program counter value for the core |
| core_retire | input | 1 | Core retired one instruction this cycle |
| core_instr | input | 32 | Word of the retired instruction |
| irq | output | 1 | Halt interrupt to host |
| irq_cause | output | 1 | 0 stop instruction, 1 budget exhausted |

## Verification
Every result is registered once. A response, a `core_pc` update, a change in `core_run` or an interrupt therefore appears in the cycle after the clock edge that sampled the command or retire strobe. The bench drives inputs on falling edges and reads outputs on the falling edge right after the sampling edge, so each result is read in the first cycle it is due.

A budgeted run is measured by counting the falling edges on which `core_run` is high. A counter read returns the value held before the read's own edge, so the expected counts add up only the edges that came before it.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int CODE_W = 4;
    localparam logic [31:0] STOP_WORD = 32'h4080_0000;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_DATA = 2'd1,
        RSP_ERR  = 2'd2
    } rsp_kind_e;

    localparam logic [CODE_W-1:0] OP_ARG     = 4'd0;
    localparam logic [CODE_W-1:0] OP_START   = 4'd1;
    localparam logic [CODE_W-1:0] OP_SETPC   = 4'd2;
    localparam logic [CODE_W-1:0] OP_BUDGET  = 4'd3;
    localparam logic [CODE_W-1:0] OP_HALT    = 4'd4;
    localparam logic [CODE_W-1:0] OP_RD_CYC  = 4'd5;
    localparam logic [CODE_W-1:0] OP_RD_INS  = 4'd6;
    localparam logic [CODE_W-1:0] OP_CLR_IRQ = 4'd7;

    // one bit per accepted operation
    typedef struct packed {
        logic arg;
        logic start;
        logic setpc;
        logic budget;
        logic halt;
        logic rd_cyc;
        logic rd_ins;
        logic clr_irq;
    } op_dec_t;

endpackage

// File: rtl/rc_cmd_decode.sv
module rc_cmd_decode
    import rc_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              busy,
    input  logic              arg_zero,
    output op_dec_t           acc,
    output logic              rej
);

    always_comb begin
        acc = '0;
        rej = 1'b0;
        if (cmd_valid) begin
            case (cmd_code)
                OP_ARG:     if (busy) rej = 1'b1; else acc.arg = 1'b1;
                OP_START:   if (busy) rej = 1'b1; else acc.start = 1'b1;
                OP_SETPC:   if (busy) rej = 1'b1; else acc.setpc = 1'b1;
                OP_BUDGET:  if (busy || arg_zero) rej = 1'b1; else acc.budget = 1'b1;
                OP_HALT:    acc.halt = 1'b1;
                OP_RD_CYC:  acc.rd_cyc = 1'b1;
                OP_RD_INS:  acc.rd_ins = 1'b1;
                OP_CLR_IRQ: if (busy) rej = 1'b1; else acc.clr_irq = 1'b1;
                default:    rej = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rc_sat_counter.sv
module rc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);

    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && cnt_q != MAXV)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign val_o = cnt_q;

endmodule

// File: rtl/rc_run_ctrl.sv
module rc_run_ctrl
    import rc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [DATA_W-1:0] cmd_arg,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              core_run,
    output logic              core_pc_load,
    output logic [DATA_W-1:0] core_pc,
    input  logic              core_retire,
    input  logic [31:0]       core_instr,
    output logic              irq,
    output logic              irq_cause
);

    localparam int NCNT   = 2;
    localparam int IX_CYC = 0;
    localparam int IX_INS = 1;

    typedef struct packed {
        logic              running;
        logic              budgeted;
        logic [DATA_W-1:0] budget;
        logic [DATA_W-1:0] arg;
        logic [DATA_W-1:0] pc;
        logic              pc_load;
        logic              irq;
        logic              cause;
        logic              rsp_valid;
        logic [1:0]        rsp_kind;
        logic [DATA_W-1:0] rsp_data;
    } st_t;

    st_t s_d, s_q;

    op_dec_t dec;
    logic    rej;

    logic [NCNT-1:0]  cnt_inc;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_val [NCNT];

    logic stop_hit, budget_end;

    rc_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .busy      (s_q.running),
        .arg_zero  (cmd_arg == '0),
        .acc       (dec),
        .rej       (rej)
    );

    assign cnt_clr         = dec.start | dec.budget;
    assign cnt_inc[IX_CYC] = s_q.running;
    assign cnt_inc[IX_INS] = s_q.running & core_retire;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        rc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (cnt_clr),
            .inc_i (cnt_inc[g]),
            .val_o (cnt_val[g])
        );
    end

    assign stop_hit   = s_q.running & core_retire & (core_instr == STOP_WORD);
    assign budget_end = s_q.running & s_q.budgeted & (s_q.budget == DATA_W'(1));

    always_comb begin
        s_d           = s_q;
        s_d.pc_load   = 1'b0;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_kind  = RSP_OK;
        s_d.rsp_data  = '0;

        // core-side events
        if (s_q.running) begin
            if (s_q.budgeted)
                s_d.budget = s_q.budget - 1'b1;
            if (stop_hit) begin
                s_d.running = 1'b0;
                s_d.irq     = 1'b1;
                s_d.cause   = 1'b0;
            end else if (budget_end) begin
                s_d.running = 1'b0;
                s_d.irq     = 1'b1;
                s_d.cause   = 1'b1;
            end
        end

        // host commands
        if (cmd_valid) begin
            s_d.rsp_valid = 1'b1;
            if (rej)
                s_d.rsp_kind = RSP_ERR;
        end
        if (dec.arg)
            s_d.arg = cmd_arg;
        if (dec.setpc) begin
            s_d.pc      = s_q.arg;
            s_d.pc_load = 1'b1;
        end
        if (dec.start) begin
            s_d.running  = 1'b1;
            s_d.budgeted = 1'b0;
            s_d.irq      = 1'b0;
            s_d.cause    = 1'b0;
        end
        if (dec.budget) begin
            s_d.pc       = s_q.arg;
            s_d.pc_load  = 1'b1;
            s_d.running  = 1'b1;
            s_d.budgeted = 1'b1;
            s_d.budget   = cmd_arg;
            s_d.irq      = 1'b0;
            s_d.cause    = 1'b0;
        end
        if (dec.halt)
            s_d.running = 1'b0;
        if (dec.rd_cyc) begin
            s_d.rsp_kind = RSP_DATA;
            s_d.rsp_data = DATA_W'(cnt_val[IX_CYC]);
        end
        if (dec.rd_ins) begin
            s_d.rsp_kind = RSP_DATA;
            s_d.rsp_data = DATA_W'(cnt_val[IX_INS]);
        end
        if (dec.clr_irq)
            s_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_kind     = s_q.rsp_kind;
    assign rsp_data     = s_q.rsp_data;
    assign core_run     = s_q.running;
    assign core_pc_load = s_q.pc_load;
    assign core_pc      = s_q.pc;
    assign irq          = s_q.irq;
    assign irq_cause    = s_q.cause;

endmodule

// File: rtl/rc_run_ctrl_chk.sv
module rc_run_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [3:0]  cmd_code,
    input logic        rsp_valid,
    input logic [1:0]  rsp_kind,
    input logic        core_run,
    input logic        core_pc_load,
    input logic        core_retire,
    input logic [31:0] core_instr,
    input logic        irq,
    input logic        irq_cause
);

    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    assert_pcload_from_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_pc_load |-> $past(cmd_valid));

    assert_stop_word_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && core_retire && core_instr == 32'h4080_0000)
        |=> (!core_run && irq && !irq_cause));

    assert_irq_only_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !core_run);

    assert_cause_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!irq || $stable(irq_cause)));

    assert_busy_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && core_run && (cmd_code <= 4'd3 || cmd_code == 4'd7))
        |=> (rsp_kind == 2'd2));

    assert_unknown_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code >= 4'd8) |=> (rsp_kind == 2'd2));

endmodule

bind rc_run_ctrl rc_run_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (rsp_kind),
    .core_run     (core_run),
    .core_pc_load (core_pc_load),
    .core_retire  (core_retire),
    .core_instr   (core_instr),
    .irq          (irq),
    .irq_cause    (irq_cause)
);

// File: tb/rc_run_ctrl_test.sv
module rc_run_ctrl_test;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int SATV   = (1 << CNT_W) - 1;
    localparam logic [31:0] STOPW = 32'h4080_0000;
    localparam logic [31:0] PLAIN = 32'h0123_4567;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_code = '0;
    logic [DATA_W-1:0] cmd_arg = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_data;
    logic              core_run;
    logic              core_pc_load;
    logic [DATA_W-1:0] core_pc;
    logic              core_retire = 1'b0;
    logic [31:0]       core_instr = '0;
    logic              irq;
    logic              irq_cause;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [31:0] last_arg;

    always #4 clk = ~clk;

    rc_run_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .cmd_arg      (cmd_arg),
        .rsp_valid    (rsp_valid),
        .rsp_kind     (rsp_kind),
        .rsp_data     (rsp_data),
        .core_run     (core_run),
        .core_pc_load (core_pc_load),
        .core_pc      (core_pc),
        .core_retire  (core_retire),
        .core_instr   (core_instr),
        .irq          (irq),
        .irq_cause    (irq_cause)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the sampling edge
    task automatic send(input logic [3:0] code, input logic [31:0] arg);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_arg   = arg;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = '0;
        cmd_arg   = '0;
    endtask

    task automatic read_cnt(input logic [3:0] code, input string req, input int exp);
        send(code, 0);
        chk({req, " rsp_kind"}, 32'(rsp_kind), 32'd1);
        chk({req, " count"}, rsp_data, 32'(exp));
    endtask

    task automatic step(input logic ret, input logic [31:0] w);
        core_retire = ret;
        core_instr  = w;
        @(posedge clk);
        @(negedge clk);
        core_retire = 1'b0;
        core_instr  = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 core_run", 32'(core_run), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 core_pc", core_pc, 0);
        chk("R1 pc_load", 32'(core_pc_load), 0);
        read_cnt(4'd5, "R1 cycles", 0);
        read_cnt(4'd6, "R1 instrs", 0);

        // R2 staged PC load; R3 response one cycle later
        send(4'd0, 32'h0000_0040);
        chk("R3 rsp_valid", 32'(rsp_valid), 1);
        chk("R2 arg ok", 32'(rsp_kind), 0);
        chk("R2 arg no pc effect", core_pc, 0);
        chk("R2 arg no pc_load", 32'(core_pc_load), 0);
        @(negedge clk);
        chk("R3 no rsp without cmd", 32'(rsp_valid), 0);
        send(4'd2, 0);
        chk("R2 pc_load pulse", 32'(core_pc_load), 1);
        chk("R2 core_pc", core_pc, 32'h40);
        @(negedge clk);
        chk("R2 pc_load one cycle", 32'(core_pc_load), 0);
        last_arg = 32'h40;

        // R4 R5 R7: start-until-stop sweep
        for (int k = 0; k < 6; k++) begin
            send(4'd0, 32'(k * 4));
            last_arg = 32'(k * 4);
            send(4'd2, 0);
            chk("R2 core_pc sweep", core_pc, 32'(k * 4));
            send(4'd1, 0);
            chk("R4 start ok", 32'(rsp_kind), 0);
            chk("R4 core_run", 32'(core_run), 1);
            chk("R4 irq cleared", 32'(irq), 0);
            for (int i = 0; i < k; i++) step(1'b1, PLAIN);
            step(1'b1, STOPW);
            chk("R5 halted", 32'(core_run), 0);
            chk("R5 irq", 32'(irq), 1);
            chk("R5 cause", 32'(irq_cause), 0);
            read_cnt(4'd5, "R7 cycles", k + 1);
            read_cnt(4'd6, "R7 instrs", k + 1);
            step(1'b1, PLAIN);
            step(1'b1, STOPW);
            read_cnt(4'd6, "R7 halted retire ignored", k + 1);
            chk("R10 irq held", 32'(irq), 1);
            send(4'd7, 0);
            chk("R10 irq cleared", 32'(irq), 0);
        end

        // R6 R7: budgeted-run sweep
        for (int n = 1; n <= 8; n++) begin
            int cnt;
            int rets;
            cnt = 0;
            rets = 0;
            send(4'd0, 32'(100 + n));
            last_arg = 32'(100 + n);
            send(4'd3, 32'(n));
            chk("R6 ok", 32'(rsp_kind), 0);
            chk("R6 pc_load", 32'(core_pc_load), 1);
            chk("R6 core_pc", core_pc, 32'(100 + n));
            while (core_run && cnt < 500) begin
                step(cnt[0], PLAIN);
                rets += cnt[0] ? 1 : 0;
                cnt++;
            end
            chk("R6 run length", 32'(cnt), 32'(n));
            chk("R6 irq", 32'(irq), 1);
            chk("R6 cause", 32'(irq_cause), 1);
            read_cnt(4'd5, "R7 budget cycles", n);
            read_cnt(4'd6, "R7 budget instrs", rets);
        end

        // R5 priority: stop word on the last budgeted cycle
        send(4'd3, 2);
        step(1'b1, PLAIN);
        step(1'b1, STOPW);
        chk("R5 priority halted", 32'(core_run), 0);
        chk("R5 priority cause", 32'(irq_cause), 0);

        // R6 zero budget rejected
        send(4'd7, 0);
        send(4'd3, 0);
        chk("R6 zero budget err", 32'(rsp_kind), 2);
        chk("R6 zero budget idle", 32'(core_run), 0);

        // R11 busy rejects, reads still served; R9 halt without irq
        send(4'd3, 20);
        send(4'd0, 32'h0000_abcd);
        chk("R11 busy arg err", 32'(rsp_kind), 2);
        send(4'd5, 0);
        chk("R11 busy read data", 32'(rsp_kind), 1);
        chk("R11 busy read value", rsp_data, 1);
        send(4'd7, 0);
        chk("R11 busy clr err", 32'(rsp_kind), 2);
        send(4'd4, 0);
        chk("R9 halt ok", 32'(rsp_kind), 0);
        chk("R9 halted", 32'(core_run), 0);
        chk("R9 no irq", 32'(irq), 0);
        send(4'd2, 0);
        chk("R11 arg unchanged", core_pc, last_arg);

        // R12 unknown codes
        for (int c = 8; c < 16; c++) begin
            send(4'(c), 32'h5);
            chk("R12 unknown err", 32'(rsp_kind), 2);
            chk("R12 no run", 32'(core_run), 0);
        end

        // R8 saturation
        send(4'd3, 70);
        begin
            int cnt;
            cnt = 0;
            while (core_run && cnt < 500) begin
                step(1'b1, PLAIN);
                cnt++;
            end
            chk("R6 long run length", 32'(cnt), 70);
        end
        read_cnt(4'd5, "R8 cycles saturate", SATV);
        read_cnt(4'd6, "R8 instrs saturate", SATV);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule